// File: doc/BRIEF.md
# CPU Program Bank Mapper

This block sits between a CPU and its program memories. It takes a 16-bit CPU address in the upper part of the memory map and turns it into a select for ROM or RAM plus a physical address, so that one fixed CPU window can look into a much larger ROM or RAM. A 2-bit banking mode sets how the 32 KiB space from 0x8000 up is split: one 32 KiB window, two 16 KiB windows, a mixed 16 KiB plus two 8 KiB layout, or four 8 KiB windows. The 8 KiB area at 0x6000 always maps to RAM through a separate RAM window register.

Bit 7 of whichever bank register serves an access decides whether that window reaches ROM (set) or RAM (clear). The lower seven bits pick an 8 KiB page. Writes into RAM are blocked unless two separate key registers hold a fixed pair of values, so a stray store cannot corrupt RAM. All outputs are registered and appear one clock after the address is presented.

Top module: `prg_bank_mapper`

## Requirements
- R1: An address from 0x6000 to 0x7FFF always selects RAM. The 8 KiB page is the 3-bit value of the RAM window register, where bit 2 is the chip select and bits 1:0 are the bank.
- R2: In mode 0, addresses 0x8000 to 0xFFFF form one 32 KiB window. It uses bank register 3 with its two low bits cleared, and the offset is address bits 14:0.
- R3: In mode 1, 0x8000 to 0xBFFF uses bank register 1 and 0xC000 to 0xFFFF uses bank register 3. Each has bit 0 cleared, and the offset is address bits 13:0.
- R4: In mode 2, 0x8000 and 0xA000 take the even and odd pages of bank register 1 (bit 0 replaced by address bit 13). 0xC000 takes bank register 2 directly and 0xE000 takes bank register 3 directly, with 8 KiB offsets.
- R5: In mode 3, the four 8 KiB windows from 0x8000 take bank registers 0, 1, 2 and 3 directly.
- R6: Above 0x7FFF, bit 7 of the selected bank value drives the ROM select when set and the RAM select when clear. The physical address is (bank bits 6:0) × 8192 plus the offset.
- R7: ram_we is asserted only when all of the following hold: the CPU access is a write, it resolves to RAM, key A holds 2 and key B holds 1. Reads and ROM-resolved writes never assert it.
- R8: A write to bank register 3 stores bit 7 as 1 whatever the data, so 0xE000 to 0xFFFF always resolves to ROM.
- R9: An address below 0x6000 drives both selects, ram_we and the physical address to zero.
- R10: After reset the mode is 3, bank register 3 is 0xFF, and every other register is 0. So 0x8000 reaches RAM page 0 and 0xE000 reaches ROM page 0x7F.
- R11: The outputs are registered. They show the result for the address and write flag sampled at a clock edge, and they hold that result until the next edge.
- R12: cfg_sel selects the register to write: 0 mode, 1 key A, 2 key B, 3 RAM window, 4 to 7 bank registers 0 to 3. Mode and the keys keep data bits 1:0 and the RAM window keeps bits 2:0. The other data bits are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU access is a write |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register index |
| cfg_data | input | 8 | Register write data |
| rom_sel | output | 1 | Access resolves to ROM |
| ram_sel | output | 1 | Access resolves to RAM |
| phys_addr | output | 20 | Physical byte address in the selected memory |
| ram_we | output | 1 | RAM write enable after key check |

## Verification
The assertions check the following on every cycle:
- ram_we never fires without a RAM select and the key pair 2/1 in place.
- The 0x6000 window always lands in RAM.
- The 0xE000 window always lands in ROM.
- Addresses below 0x6000 leave every output quiet.
- The physical offset always repeats the low 13 address bits.

Only the bench scenarios can show the exact page arithmetic of each mode, the reset register values, the field masking on register writes, the one-cycle latency and a RAM-backed window above 0x7FFF.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  typedef enum logic [1:0] {
    MAP_32K   = 2'd0,
    MAP_16K   = 2'd1,
    MAP_MIXED = 2'd2,
    MAP_8K    = 2'd3
  } map_mode_e;

  localparam logic [2:0] CFG_MODE  = 3'd0;
  localparam logic [2:0] CFG_KEY_A = 3'd1;
  localparam logic [2:0] CFG_KEY_B = 3'd2;
  localparam logic [2:0] CFG_RAMW  = 3'd3;

  localparam logic [1:0] KEY_A_OPEN = 2'd2;
  localparam logic [1:0] KEY_B_OPEN = 2'd1;

endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 3,
  parameter int N_BANKS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic [DATA_W-1:0]              cfg_data,
  output map_mode_e                      mode_q,
  output logic [1:0]                     key_a_q,
  output logic [1:0]                     key_b_q,
  output logic [2:0]                     ramw_q,
  output logic [N_BANKS-1:0][DATA_W-1:0] bank_q
);

  localparam int IDX_W = $clog2(N_BANKS);

  logic bank_grp;
  assign bank_grp = cfg_sel[SEL_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MAP_8K;
      key_a_q <= '0;
      key_b_q <= '0;
      ramw_q  <= '0;
    end else if (cfg_we && !bank_grp) begin
      case (cfg_sel)
        CFG_MODE:  mode_q  <= map_mode_e'(cfg_data[1:0]);
        CFG_KEY_A: key_a_q <= cfg_data[1:0];
        CFG_KEY_B: key_b_q <= cfg_data[1:0];
        CFG_RAMW:  ramw_q  <= cfg_data[2:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
    localparam bit TOP = (i == N_BANKS - 1);
    logic hit;
    assign hit = cfg_we && bank_grp && (cfg_sel[IDX_W-1:0] == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[i] <= TOP ? '1 : '0;
      end else if (hit) begin
        if (TOP) bank_q[i] <= {1'b1, cfg_data[DATA_W-2:0]};
        else     bank_q[i] <= cfg_data;
      end
    end
  end

endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OFFS_W  = 13,
  parameter int N_BANKS = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  input  map_mode_e                      mode,
  input  logic [2:0]                     ramw,
  input  logic [N_BANKS-1:0][DATA_W-1:0] bank,
  output logic                           hit,
  output logic                           is_rom,
  output logic [DATA_W-2:0]              page,
  output logic [OFFS_W-1:0]              offset
);

  localparam int BANK_W = DATA_W - 1;

  logic [DATA_W-1:0] sel;
  logic [1:0]        win;

  assign win    = addr[ADDR_W-2:ADDR_W-3];
  assign offset = addr[OFFS_W-1:0];

  always_comb begin
    hit    = 1'b0;
    is_rom = 1'b0;
    page   = '0;
    sel    = '0;
    if (addr[ADDR_W-1]) begin
      hit = 1'b1;
      unique case (mode)
        MAP_32K: begin
          sel  = bank[3];
          page = {sel[BANK_W-1:2], win};
        end
        MAP_16K: begin
          sel  = win[1] ? bank[3] : bank[1];
          page = {sel[BANK_W-1:1], win[0]};
        end
        MAP_MIXED: begin
          if (!win[1]) begin
            sel  = bank[1];
            page = {sel[BANK_W-1:1], win[0]};
          end else begin
            sel  = win[0] ? bank[3] : bank[2];
            page = sel[BANK_W-1:0];
          end
        end
        default: begin
          sel  = bank[win];
          page = sel[BANK_W-1:0];
        end
      endcase
      is_rom = sel[DATA_W-1];
    end else if (addr[ADDR_W-2:ADDR_W-3] == 2'b11) begin
      hit  = 1'b1;
      page = {{(BANK_W-3){1'b0}}, ramw};
    end
  end

endmodule

// File: rtl/prg_out_stage.sv
module prg_out_stage #(
  parameter int BANK_W = 7,
  parameter int OFFS_W = 13,
  parameter int PHYS_W = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              is_rom,
  input  logic [BANK_W-1:0] page,
  input  logic [OFFS_W-1:0] offset,
  input  logic              cpu_we,
  input  logic              unlocked,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              ram_we
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel   <= 1'b0;
      ram_sel   <= 1'b0;
      phys_addr <= '0;
      ram_we    <= 1'b0;
    end else begin
      rom_sel   <= hit && is_rom;
      ram_sel   <= hit && !is_rom;
      phys_addr <= hit ? {page, offset} : '0;
      ram_we    <= hit && !is_rom && cpu_we && unlocked;
    end
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OFFS_W  = 13,
  parameter int SEL_W   = 3,
  parameter int N_BANKS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic                          cpu_we,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [DATA_W-1:0]             cfg_data,
  output logic                          rom_sel,
  output logic                          ram_sel,
  output logic [DATA_W-1+OFFS_W-1:0]    phys_addr,
  output logic                          ram_we
);

  localparam int BANK_W = DATA_W - 1;
  localparam int PHYS_W = BANK_W + OFFS_W;

  map_mode_e                      mode;
  logic [1:0]                     key_a, key_b;
  logic [2:0]                     ramw;
  logic [N_BANKS-1:0][DATA_W-1:0] bank;
  logic                           hit, is_rom, unlocked;
  logic [BANK_W-1:0]              page;
  logic [OFFS_W-1:0]              offset;

  prg_bank_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .N_BANKS(N_BANKS)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mode_q(mode), .key_a_q(key_a), .key_b_q(key_b), .ramw_q(ramw), .bank_q(bank)
  );

  prg_window_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .N_BANKS(N_BANKS)) u_dec (
    .addr(cpu_addr), .mode(mode), .ramw(ramw), .bank(bank),
    .hit(hit), .is_rom(is_rom), .page(page), .offset(offset)
  );

  assign unlocked = (key_a == KEY_A_OPEN) && (key_b == KEY_B_OPEN);

  prg_out_stage #(.BANK_W(BANK_W), .OFFS_W(OFFS_W), .PHYS_W(PHYS_W)) u_out (
    .clk(clk), .rst(rst), .hit(hit), .is_rom(is_rom), .page(page), .offset(offset),
    .cpu_we(cpu_we), .unlocked(unlocked),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .phys_addr(phys_addr), .ram_we(ram_we)
  );

  AST_WE_NEEDS_RAM: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_sel); // R7
  AST_WE_NEEDS_KEYS: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(key_a) == KEY_A_OPEN && $past(key_b) == KEY_B_OPEN)); // R7
  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cpu_addr < 16'h6000)) |->
      (!rom_sel && !ram_sel && !ram_we && phys_addr == '0)); // R9
  AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cpu_addr[ADDR_W-1:ADDR_W-3] == 3'b011)) |-> (ram_sel && !rom_sel)); // R1
  AST_TOP_WINDOW_ROM: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cpu_addr[ADDR_W-1:ADDR_W-3] == 3'b111)) |-> rom_sel); // R8
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (rom_sel || ram_sel) |-> (phys_addr[OFFS_W-1:0] == $past(cpu_addr[OFFS_W-1:0]))); // R6

endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        rom_sel, ram_sel, ram_we;
  logic [19:0] phys_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_mode, m_ka, m_kb, m_ram;
  int m_bank [4];

  always #5 clk = ~clk;

  prg_bank_mapper dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .phys_addr(phys_addr), .ram_we(ram_we)
  );

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic model_reset();
    m_mode = 3; m_ka = 0; m_kb = 0; m_ram = 0;
    m_bank[0] = 0; m_bank[1] = 0; m_bank[2] = 0; m_bank[3] = 'hFF;
  endtask

  // R12: register index map and field widths
  task automatic cfg(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_mode = data & 3;
      1: m_ka = data & 3;
      2: m_kb = data & 3;
      3: m_ram = data & 7;
      7: m_bank[3] = (data & 'hFF) | 'h80;
      default: m_bank[sel - 4] = data & 'hFF;
    endcase
  endtask

  function automatic logic [22:0] expect_of(input int a, input bit we);
    int b, off;
    bit hit, rom, wen;
    int ph;
    hit = 1; rom = 0; b = 0; off = 0;
    if (a < 'h6000) hit = 0;
    else if (a < 'h8000) begin b = m_ram; off = a & 'h1FFF; end
    else begin
      case (m_mode)
        0: begin b = m_bank[3] & ~3; off = a & 'h7FFF; end
        1: begin b = ((a < 'hC000) ? m_bank[1] : m_bank[3]) & ~1; off = a & 'h3FFF; end
        2: begin
          if (a < 'hC000) begin b = m_bank[1] & ~1; off = a & 'h3FFF; end
          else begin b = (a < 'hE000) ? m_bank[2] : m_bank[3]; off = a & 'h1FFF; end
        end
        default: begin b = m_bank[(a - 'h8000) / 'h2000]; off = a & 'h1FFF; end
      endcase
      rom = (b & 'h80) != 0;
    end
    ph  = hit ? ((b & 'h7F) * 8192 + off) : 0;
    wen = we && hit && !rom && m_ka == 2 && m_kb == 1;
    return {hit && rom, hit && !rom, wen, 20'(ph)};
  endfunction

  task automatic look(input string req, input int a, input bit we);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_we = we;
    @(negedge clk);
    check(req, {rom_sel, ram_sel, ram_we, phys_addr}, expect_of(a, we));
    cpu_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 outputs in reset", {rom_sel, ram_sel, ram_we, phys_addr}, '0);
    @(negedge clk); rst = 1'b0;
    look("R10 0x8000 RAM page 0", 'h8123, 0);
    check("R10 explicit", {rom_sel, ram_sel, phys_addr}, {2'b01, 20'h00123});
    look("R10 0xE000 ROM page 7F", 'hE456, 0);
    check("R10 explicit top", {rom_sel, ram_sel, phys_addr}, {2'b10, 20'hFE456});
  endtask

  task automatic t_low();
    look("R9 address 0x0000", 'h0000, 1);
    look("R9 address 0x5FFF", 'h5FFF, 1);
  endtask

  task automatic t_ram_window();
    cfg(3, 'h05);
    look("R1 ram window 5", 'h6ABC, 0);
    cfg(3, 'hFF);
    look("R12 ram window mask", 'h7FFF, 0);
    check("R1 page 7", phys_addr, 20'h0FFFF);
  endtask

  task automatic t_modes();
    cfg(4, 'h91); cfg(5, 'hA3); cfg(6, 'h8C); cfg(7, 'h37);
    cfg(0, 'h00);
    look("R2 mode0 lo", 'h8001, 0);
    look("R2 mode0 hi", 'hF7FE, 0);
    check("R2 explicit", phys_addr, 20'h6F7FE);
    cfg(0, 1);
    look("R3 mode1 lower", 'hA010, 0);
    look("R3 mode1 upper", 'hC020, 0);
    look("R3 mode1 upper odd", 'hE020, 0);
    cfg(0, 'hFE);
    look("R4 mode2 even", 'h8100, 0);
    look("R4 mode2 odd", 'hA100, 0);
    look("R4 mode2 c000", 'hC200, 0);
    look("R4 mode2 e000", 'hE300, 0);
    cfg(0, 3);
    look("R5 mode3 w0", 'h8000, 0);
    look("R5 mode3 w1", 'hBFFF, 0);
    look("R5 mode3 w2", 'hC001, 0);
    look("R5 mode3 w3", 'hFFFF, 0);
  endtask

  task automatic t_bit7();
    cfg(5, 'h12);
    look("R6 bank bit7 clear gives RAM", 'hA777, 0);
    check("R6 explicit", {rom_sel, ram_sel, phys_addr}, {2'b01, 20'h24777});
    cfg(5, 'hF2);
    look("R6 bank bit7 set gives ROM", 'hA777, 0);
  endtask

  task automatic t_top_force();
    cfg(7, 'h05);
    look("R8 bank3 forced ROM", 'hE001, 1);
    check("R8 explicit", {rom_sel, ram_we, phys_addr}, {2'b10, 20'h0A001});
  endtask

  task automatic t_protect();
    look("R7 locked RAM write", 'h6010, 1);
    cfg(1, 'hFE); cfg(2, 1);
    look("R7 unlocked RAM write", 'h6010, 1);
    check("R7 explicit we", ram_we, 1'b1);
    look("R7 unlocked read", 'h6010, 0);
    look("R7 ROM write no we", 'hE010, 1);
    cfg(4, 'h03);
    look("R7 RAM write via 0x8000", 'h8010, 1);
    cfg(2, 2);
    look("R7 wrong key B", 'h6010, 1);
    cfg(1, 1); cfg(2, 1);
    look("R7 wrong key A", 'h6010, 1);
  endtask

  task automatic t_latency();
    @(negedge clk);
    cpu_addr = 16'h0100;
    @(negedge clk);
    cpu_addr = 16'hE000;
    #2;
    check("R11 holds before edge", {rom_sel, ram_sel, phys_addr}, '0);
    @(negedge clk);
    check("R11 updates after edge", {rom_sel, ram_sel, ram_we, phys_addr}, expect_of('hE000, 0));
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    t_reset();
    t_low();
    t_ram_window();
    t_modes();
    t_bit7();
    t_top_force();
    t_protect();
    t_latency();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

endmodule